// File: doc/BRIEF.md
# Receive FIFO Identifier Acceptance Filter

This block decides whether a received CAN frame may be placed into a receive FIFO. It does this by comparing the frame identifier with a small table of programmable acceptance entries. Each entry has its own mask. The filter runs beside the mailbox matching logic and is fed from the same frame-valid strobe. It returns a registered accept flag together with the number of the matching entry.

The table is eight 32-bit words, and a second set of eight words holds the masks. A static format select decides how each word is read:

- as one full entry (8 entries in total),
- as two 16-bit standard entries (16 in total),
- as four 8-bit identifier slices (32 in total).

A fourth setting turns the filter off. Software loads table and mask words through a simple write strobe. FIFO storage, bit timing and frame decoding belong to other blocks.

Top module: `rxfifo_id_filter`

## Requirements
- R1: The result appears in the cycle after a clock edge that sees `frm_valid` high. At that point `res_valid` is 1, and `res_accept` and `res_idx` carry the outcome. In every other cycle `res_valid` and `res_accept` are 0. `res_idx` is 0 whenever `res_accept` is 0.
- R2: With `cfg_fmt`=0, word w is entry w. Bit 31 is the expected RTR, bit 30 the expected IDE, and bits 28:0 the identifier. The identifier is compared with the frame ID under mask bits 28:0.
- R3: In formats 0 and 1 an entry matches only if its RTR and IDE bits both equal the frame's flags, whatever the mask holds.
- R4: With `cfg_fmt`=1, bits 31:16 of word w form entry 2w and bits 15:0 form entry 2w+1. Within a half, bit 15 is RTR, bit 14 is IDE and bits 10:0 are an 11-bit ID. The mask sits in the same half-word positions. The 11-bit ID is compared with frame ID bits 10:0 for a standard frame and bits 28:18 for an extended frame.
- R5: With `cfg_fmt`=2, byte 3 of word w is entry 4w, byte 2 is 4w+1, byte 1 is 4w+2 and byte 0 is 4w+3. Each byte is compared under its mask byte with the eight most significant ID bits. These are bits 28:21 for an extended frame and bits 10:3 for a standard frame. RTR and IDE are ignored.
- R6: A mask bit of 1 makes the corresponding bit take part in the comparison. A mask bit of 0 ignores it.
- R7: When several entries match, the lowest-numbered entry is reported.
- R8: With `cfg_fmt`=3 every frame is rejected.
- R9: Reset clears all table and mask words to zero.
- R10: When `wr_en` is high, `wr_data` is stored in the mask word (`wr_sel`=1) or the table word (`wr_sel`=0) addressed by `wr_addr`. The new value governs frames strobed from the next cycle on. A frame strobed in the same cycle as the write still sees the old value.
- R11: For a standard frame (`frm_ide`=0), ID bits 28:11 are ignored in every format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Table format: 0 full, 1 halves, 2 slices, 3 off |
| wr_en | input | 1 | Table/mask write strobe |
| wr_sel | input | 1 | 0 writes the table word, 1 writes the mask word |
| wr_addr | input | 3 | Word address |
| wr_data | input | 32 | Write data |
| frm_valid | input | 1 | Received frame strobe |
| frm_ide | input | 1 | Frame uses an extended identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Frame identifier; a standard ID sits in bits 10:0 |
| res_valid | output | 1 | Result strobe |
| res_accept | output | 1 | Frame accepted into the FIFO |
| res_idx | output | 5 | Number of the lowest matching entry |

## Verification
Each format is tried with the following frames:
- a frame that hits an exact entry;
- a frame that hits only a partially masked entry;
- a frame that differs from an entry only in a masked-in bit;
- a frame of the wrong type carrying a matching ID.

Together these separate correct mask polarity from flag comparison. Frames that hit two entries, together with hits on the first and last slice positions, expose the priority order and any mistake in byte or half-word placement. Further cases cover:
- standard frames carrying junk in the upper identifier bits;
- the table's post-reset contents;
- a write in the same cycle as a frame strobe, which shows exactly when new table data takes effect.

// File: rtl/rxfifo_id_filter.sv
module rxfifo_id_filter #(
  parameter int WORDS = 8,
  localparam int AW = $clog2(WORDS),
  localparam int NENT = 4 * WORDS,
  localparam int IDXW = $clog2(NENT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_fmt,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [AW-1:0]   wr_addr,
  input  logic [31:0]     wr_data,
  input  logic            frm_valid,
  input  logic            frm_ide,
  input  logic            frm_rtr,
  input  logic [28:0]     frm_id,
  output logic            res_valid,
  output logic            res_accept,
  output logic [IDXW-1:0] res_idx
);

  logic [31:0] tbl [WORDS];
  logic [31:0] msk [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) begin
        tbl[w] <= '0;
        msk[w] <= '0;
      end
    end else if (wr_en) begin
      if (wr_sel) msk[wr_addr] <= wr_data;
      else        tbl[wr_addr] <= wr_data;
    end
  end

  wire [28:0] id_full = frm_ide ? frm_id : {18'b0, frm_id[10:0]};
  wire [10:0] id_half = frm_ide ? frm_id[28:18] : frm_id[10:0];
  wire [7:0]  id_top  = frm_ide ? frm_id[28:21] : frm_id[10:3];

  logic [WORDS-1:0]   full_hit;
  logic [2*WORDS-1:0] half_hit;
  logic [NENT-1:0]    slice_hit;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign full_hit[w] = (tbl[w][31] == frm_rtr) && (tbl[w][30] == frm_ide) &&
                         (((tbl[w][28:0] ^ id_full) & msk[w][28:0]) == '0);
    for (genvar h = 0; h < 2; h++) begin : g_half
      wire [15:0] ent = tbl[w][31-16*h -: 16];
      wire [15:0] em  = msk[w][31-16*h -: 16];
      assign half_hit[2*w+h] = (ent[15] == frm_rtr) && (ent[14] == frm_ide) &&
                               (((ent[10:0] ^ id_half) & em[10:0]) == '0);
    end
    for (genvar s = 0; s < 4; s++) begin : g_slice
      assign slice_hit[4*w+s] =
        ((tbl[w][31-8*s -: 8] ^ id_top) & msk[w][31-8*s -: 8]) == '0;
    end
  end

  logic [NENT-1:0] hits;
  always_comb begin
    hits = '0;
    case (cfg_fmt)
      2'd0:    hits[WORDS-1:0]   = full_hit;
      2'd1:    hits[2*WORDS-1:0] = half_hit;
      2'd2:    hits              = slice_hit;
      default: hits              = '0;
    endcase
  end

  logic [IDXW-1:0] first;
  always_comb begin
    first = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (hits[i]) first = IDXW'(i);
  end

  wire take = frm_valid && (hits != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_idx    <= '0;
    end else begin
      res_valid  <= frm_valid;
      res_accept <= take;
      res_idx    <= take ? first : '0;
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid);
  // R1
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_valid);
  // R1
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> res_valid);
  // R1
  idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_accept |-> res_idx == '0);
  // R8
  off_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && cfg_fmt == 2'd3) |=> !res_accept);
  // R2
  full_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && cfg_fmt == 2'd0) |=> res_idx < IDXW'(WORDS));
  // R4
  half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && cfg_fmt == 2'd1) |=> res_idx < IDXW'(2 * WORDS));

endmodule

// File: tb/rxfifo_id_filter_tb.sv
module rxfifo_id_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_fmt = 2'd0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic frm_valid = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic res_valid, res_accept;
  logic [4:0] res_idx;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxfifo_id_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .frm_valid(frm_valid), .frm_ide(frm_ide),
    .frm_rtr(frm_rtr), .frm_id(frm_id), .res_valid(res_valid),
    .res_accept(res_accept), .res_idx(res_idx));

  // {fmt, ide, rtr, id, accept, idx}
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 29'h1234567, 1'b1, 5'd0},   // R7 hits 0 and 2
    {2'd0, 1'b1, 1'b0, 29'h123456A, 1'b1, 5'd2},   // R6 masked low nibble
    {2'd0, 1'b1, 1'b0, 29'h1234570, 1'b0, 5'd0},   // R6 masked-in bit differs
    {2'd0, 1'b0, 1'b1, 29'h0000123, 1'b1, 5'd1},
    {2'd0, 1'b0, 1'b0, 29'h0000123, 1'b0, 5'd0},   // R3 RTR mismatch
    {2'd0, 1'b1, 1'b1, 29'h0ABCDEF, 1'b1, 5'd4},
    {2'd0, 1'b0, 1'b0, 29'h1FFFF555, 1'b1, 5'd3},  // R11 upper junk
    {2'd0, 1'b1, 1'b0, 29'h0000555, 1'b0, 5'd0},   // R3 IDE mismatch
    {2'd1, 1'b0, 1'b0, 29'h0000100, 1'b1, 5'd0},
    {2'd1, 1'b0, 1'b0, 29'h00001FF, 1'b1, 5'd1},
    {2'd1, 1'b0, 1'b0, 29'h0000200, 1'b0, 5'd0},
    {2'd1, 1'b1, 1'b0, 29'h0AABFFFF, 1'b1, 5'd2},
    {2'd1, 1'b0, 1'b1, 29'h00007FF, 1'b1, 5'd3},
    {2'd1, 1'b1, 1'b1, 29'h0000001, 1'b1, 5'd4},
    {2'd1, 1'b0, 1'b0, 29'h00002AA, 1'b0, 5'd0},   // R3 type mismatch
    {2'd2, 1'b1, 1'b0, 29'h15600000, 1'b1, 5'd0},
    {2'd2, 1'b1, 1'b0, 29'h02400000, 1'b1, 5'd1},
    {2'd2, 1'b0, 1'b1, 29'h00001A0, 1'b1, 5'd2},
    {2'd2, 1'b1, 1'b0, 29'h0AC00000, 1'b1, 5'd3},
    {2'd2, 1'b1, 1'b1, 29'h0000000, 1'b1, 5'd4},
    {2'd2, 1'b0, 1'b0, 29'h1FFFF638, 1'b1, 5'd31},
    {2'd2, 1'b0, 1'b0, 29'h00004C8, 1'b0, 5'd0},
    {2'd3, 1'b1, 1'b0, 29'h1234567, 1'b0, 5'd0}
  };

  task automatic check(input string tag, input logic va, input logic acc,
                       input logic [4:0] idx, input logic eva, input logic eacc,
                       input logic [4:0] eidx);
    total++;
    if (va !== eva || acc !== eacc || idx !== eidx) begin
      bad++;
      $display("FAIL %s: got valid=%0b accept=%0b idx=%0d expected valid=%0b accept=%0b idx=%0d",
               tag, va, acc, idx, eva, eacc, eidx);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic ide, input logic rtr, input logic [28:0] id);
    @(negedge clk);
    frm_valid = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic program_fmt(input logic [1:0] f);
    case (f)
      2'd0: begin
        wr(0, 0, 32'h41234567); wr(1, 0, 32'h1FFFFFFF);
        wr(0, 1, 32'h80000123); wr(1, 1, 32'h000007FF);
        wr(0, 2, 32'h41234560); wr(1, 2, 32'h1FFFFFF0);
        wr(0, 3, 32'h00000555); wr(1, 3, 32'h000007FF);
        for (int w = 4; w < 8; w++) begin
          wr(0, 3'(w), 32'hC0000000); wr(1, 3'(w), 32'h0);
        end
      end
      2'd1: begin
        wr(0, 0, 32'h01000100); wr(1, 0, 32'h07FF0700);
        wr(0, 1, 32'h42AA87FF); wr(1, 1, 32'h07FF07FF);
        for (int w = 2; w < 8; w++) begin
          wr(0, 3'(w), 32'hC000C000); wr(1, 3'(w), 32'h0);
        end
      end
      2'd2: begin
        wr(0, 0, 32'hAB123456); wr(1, 0, 32'hFFFFFFFF);
        for (int w = 1; w < 7; w++) begin
          wr(0, 3'(w), 32'h0); wr(1, 3'(w), 32'hFFFFFFFF);
        end
        wr(0, 7, 32'h000000C0); wr(1, 7, 32'hFFFFFFF0);
      end
      default: ;
    endcase
    cfg_fmt = f;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", res_valid, res_accept, res_idx, 1'b0, 1'b0, 5'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: cleared table, format 0: flags zero, mask zero
    send(1'b0, 1'b0, 29'h7AB);
    check("R9 std data after reset", res_valid, res_accept, res_idx, 1'b1, 1'b1, 5'd0);
    send(1'b1, 1'b0, 29'h7AB);
    check("R9 ext data after reset", res_valid, res_accept, res_idx, 1'b1, 1'b0, 5'd0);
    @(negedge clk);
    check("R1 no strobe", res_valid, res_accept, res_idx, 1'b0, 1'b0, 5'd0);

    begin
      logic [1:0] cur;
      cur = 2'd3;
      for (int i = 0; i < NV; i++) begin
        logic [1:0] f;
        string tag;
        f = VEC[i][38:37];
        if (f != cur) begin program_fmt(f); cur = f; end
        send(VEC[i][36], VEC[i][35], VEC[i][34:6]);
        case (f)
          2'd0: tag = $sformatf("R2 vec %0d", i);
          2'd1: tag = $sformatf("R4 vec %0d", i);
          2'd2: tag = $sformatf("R5 vec %0d", i);
          default: tag = $sformatf("R8 vec %0d", i);
        endcase
        check(tag, res_valid, res_accept, res_idx, 1'b1, VEC[i][5], VEC[i][4:0]);
      end
    end

    program_fmt(2'd0);
    // R10: write and frame in the same cycle, frame sees old entry
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 3'd3; wr_data = 32'h00000666;
    frm_valid = 1'b1; frm_ide = 1'b0; frm_rtr = 1'b0; frm_id = 29'h555;
    @(negedge clk);
    wr_en = 1'b0; frm_valid = 1'b0;
    check("R10 same-cycle old value", res_valid, res_accept, res_idx, 1'b1, 1'b1, 5'd3);
    send(1'b0, 1'b0, 29'h555);
    check("R10 old id gone", res_valid, res_accept, res_idx, 1'b1, 1'b0, 5'd0);
    send(1'b0, 1'b0, 29'h666);
    check("R10 new id", res_valid, res_accept, res_idx, 1'b1, 1'b1, 5'd3);
    wr(1'b1, 3'd3, 32'h0);
    send(1'b0, 1'b0, 29'h001);
    check("R6 mask cleared", res_valid, res_accept, res_idx, 1'b1, 1'b1, 5'd3);
    @(negedge clk);
    check("R1 idle after frame", res_valid, res_accept, res_idx, 1'b0, 1'b0, 5'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule